// File: doc/BRIEF.md
# NAND Controller Operation Register Block

This block is the host-facing register bank of a NAND flash controller. A host reads and writes eight 16-bit registers over a simple single-cycle bus. Through them it selects the RAM buffer and the active chip, sets the chip enable, the pages-per-block code and the interrupt mask, and stores the spare-area size, the write-protect command and the unlock block range. One register launches flash operations. Each operation bit selects one kind of cycle. The same register reports completion in bit 15. The interrupt line is that completion flag, gated by a mask bit.

The pin sequencing toward the flash is not modelled. A stub engine stands in for it and finishes each operation a programmable number of cycles after launch. Only one operation runs at a time. A soft reset bit returns every register to its default state for a fixed number of cycles and then clears itself. The host bus has no back-pressure. A write takes effect at the clock edge on which it is presented. Read data is combinational from the address. All other pins are plain level signals.

Register word addresses: 0 buffer select, 1 configuration, 2 operation, 3 spare size, 4 write protect, 5 unlock start block, 6 unlock end block, 7 engine latency.

Top module: `nand_opreg_block`

## Requirements
- R1: After reset the registers read as follows. Address 0 reads 0x0000, address 1 reads 0x0000, address 2 reads 0x0000, address 3 reads 0x0000, address 4 reads 0x0000, address 5 reads 0x0000, address 6 reads 0xFFFF and address 7 reads the default latency of 4. The irq_o, busy_o and chip_en_o outputs are all low.
- R2: In the buffer select register, bits 2:0 drive buf_sel_o and bits 6:5 drive chip_sel_o. Every other bit of that register reads 0.
- R3: The configuration register behaves as follows:
  - bit 7 drives chip_en_o;
  - bit 4 is the interrupt mask;
  - bits 10:9 hold the pages-per-block code (0 for 32, 1 for 64, 2 for 128, 3 for 256);
  - all other bits except bit 6 read 0.
- R4: A write to the operation register while idle, with exactly one of bits 5:0 set, launches an operation. The bits are: 0 command, 1 address, 2 page program, 3 page read, 4 ID read, 5 status read. busy_o then stays high for L cycles, where L is the latency register. The launched bit reads back while busy. On completion the operation bits read 0 and bit 15 reads 1.
- R5: A write to the operation register with none, or more than one, of bits 5:0 set launches nothing.
- R6: Any write to the operation register while busy_o is high has no effect. This includes the write presented in the completion cycle, so the done flag still sets.
- R7: When idle, writing the operation register with bit 15 at 0 clears the done flag. Writing it with bit 15 at 1 leaves the flag unchanged.
- R8: irq_o is high exactly when the done flag is set and configuration bit 4 is 0.
- R9: Writing configuration bit 6 as 1 starts a soft reset. For the next 6 cycles, bit 6 reads 1, all registers hold their R1 defaults, host writes are ignored and any running operation is aborted. Afterwards bit 6 reads 0.
- R10: The registers at addresses 3, 5 and 6 store all 16 bits. The write-protect register keeps bits 2:0 (0 lock-tight, 1 lock, 2 unlock). The latency register keeps 8 bits, and a latency of 0 behaves as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Completion interrupt |
| busy_o | output | 1 | Operation in progress |
| chip_en_o | output | 1 | Flash chip enable |
| chip_sel_o | output | 2 | Active chip number |
| buf_sel_o | output | 3 | Selected RAM buffer |

## Verification
Two events can land on the same clock edge: the engine finishing an operation and a host write to the operation register, for example a write that clears the done flag. The bench times a clearing write so that it is presented in exactly the cycle the programmed latency expires. It then expects the write to be dropped: the done flag set, the operation bits zero and irq_o high. A second collision is a host write issued during a soft reset. That write must leave the register at its default once the reset bit reads 0 again.

// File: rtl/nand_opreg_pkg.sv
package nand_opreg_pkg;
  localparam int NUM_REGS = 8;
  localparam int ADDR_W   = $clog2(NUM_REGS);
  localparam int DATA_W   = 16;
  localparam int OP_BITS  = 6;

  localparam logic [ADDR_W-1:0] A_BUFSEL = 3'd0;
  localparam logic [ADDR_W-1:0] A_CFG    = 3'd1;
  localparam logic [ADDR_W-1:0] A_OP     = 3'd2;
  localparam logic [ADDR_W-1:0] A_SPARE  = 3'd3;
  localparam logic [ADDR_W-1:0] A_WPROT  = 3'd4;
  localparam logic [ADDR_W-1:0] A_ULO    = 3'd5;
  localparam logic [ADDR_W-1:0] A_UHI    = 3'd6;
  localparam logic [ADDR_W-1:0] A_LAT    = 3'd7;

  localparam int CFG_MASK_BIT = 4;
  localparam int CFG_SRST_BIT = 6;
  localparam int CFG_CE_BIT   = 7;
  localparam int OP_DONE_BIT  = 15;

  typedef enum logic [2:0] {
    OPK_CMD    = 3'd0,
    OPK_ADDR   = 3'd1,
    OPK_PROG   = 3'd2,
    OPK_READ   = 3'd3,
    OPK_ID     = 3'd4,
    OPK_STATUS = 3'd5
  } op_kind_e;
endpackage

// File: rtl/nand_stub_engine.sv
module nand_stub_engine #(
  parameter int LAT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             start,
  input  logic [LAT_W-1:0] lat,
  output logic             busy,
  output logic             fin
);
  logic [LAT_W-1:0] cnt_q;
  logic             busy_q;

  assign busy = busy_q;
  assign fin  = busy_q && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (clr) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= (lat == '0) ? '0 : lat - 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/nand_soft_reset.sv
module nand_soft_reset #(
  parameter int CYCLES = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic active
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt_q;

  assign active = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (kick && !active) cnt_q <= CW'(CYCLES);
    else if (active)         cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/nand_opreg_block.sv
module nand_opreg_block
  import nand_opreg_pkg::*;
#(
  parameter int LAT_W     = 8,
  parameter int DEF_LAT   = 4,
  parameter int SRST_CYCS = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              busy_o,
  output logic              chip_en_o,
  output logic [1:0]        chip_sel_o,
  output logic [2:0]        buf_sel_o
);
  logic [2:0]         bsel_q;
  logic [1:0]         csel_q;
  logic               mask_q, ce_q;
  logic [1:0]         ppb_q;
  logic [OP_BITS-1:0] op_q;
  logic               done_q;
  logic [DATA_W-1:0]  spare_q, ulo_q, uhi_q;
  logic [2:0]         wprot_q;
  logic [LAT_W-1:0]   lat_q;

  logic srst_active, srst_kick, clr, eng_busy, eng_fin;
  logic wr_ok, wr_op, launch;

  assign wr_ok     = bus_wr && !srst_active;
  assign srst_kick = wr_ok && bus_addr == A_CFG && bus_wdata[CFG_SRST_BIT];
  assign clr       = srst_active || srst_kick;
  assign wr_op     = wr_ok && bus_addr == A_OP;
  assign launch    = wr_op && !eng_busy && $onehot(bus_wdata[OP_BITS-1:0]);

  nand_soft_reset #(.CYCLES(SRST_CYCS)) u_srst (
    .clk(clk), .rst_n(rst_n), .kick(srst_kick), .active(srst_active)
  );

  nand_stub_engine #(.LAT_W(LAT_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .clr(clr), .start(launch),
    .lat(lat_q), .busy(eng_busy), .fin(eng_fin)
  );

  // Plain configuration storage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || clr) begin
      bsel_q  <= '0;
      csel_q  <= '0;
      mask_q  <= 1'b0;
      ce_q    <= 1'b0;
      ppb_q   <= '0;
      spare_q <= '0;
      wprot_q <= '0;
      ulo_q   <= '0;
      uhi_q   <= '1;
      lat_q   <= LAT_W'(DEF_LAT);
    end else if (wr_ok) begin
      case (bus_addr)
        A_BUFSEL: begin
          bsel_q <= bus_wdata[2:0];
          csel_q <= bus_wdata[6:5];
        end
        A_CFG: begin
          mask_q <= bus_wdata[CFG_MASK_BIT];
          ce_q   <= bus_wdata[CFG_CE_BIT];
          ppb_q  <= bus_wdata[10:9];
        end
        A_SPARE: spare_q <= bus_wdata;
        A_WPROT: wprot_q <= bus_wdata[2:0];
        A_ULO:   ulo_q   <= bus_wdata;
        A_UHI:   uhi_q   <= bus_wdata;
        A_LAT:   lat_q   <= bus_wdata[LAT_W-1:0];
        default: ;
      endcase
    end
  end

  // Operation and completion state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || clr) begin
      op_q   <= '0;
      done_q <= 1'b0;
    end else if (eng_fin) begin
      op_q   <= '0;
      done_q <= 1'b1;
    end else if (wr_op && !eng_busy) begin
      if (!bus_wdata[OP_DONE_BIT]) done_q <= 1'b0;
      if (launch) op_q <= bus_wdata[OP_BITS-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_BUFSEL: begin
        bus_rdata[2:0] = bsel_q;
        bus_rdata[6:5] = csel_q;
      end
      A_CFG: begin
        bus_rdata[CFG_MASK_BIT] = mask_q;
        bus_rdata[CFG_SRST_BIT] = srst_active;
        bus_rdata[CFG_CE_BIT]   = ce_q;
        bus_rdata[10:9]         = ppb_q;
      end
      A_OP: begin
        bus_rdata[OP_BITS-1:0] = op_q;
        bus_rdata[OP_DONE_BIT] = done_q;
      end
      A_SPARE: bus_rdata = spare_q;
      A_WPROT: bus_rdata[2:0] = wprot_q;
      A_ULO:   bus_rdata = ulo_q;
      A_UHI:   bus_rdata = uhi_q;
      A_LAT:   bus_rdata[LAT_W-1:0] = lat_q;
      default: bus_rdata = '0;
    endcase
  end

  assign irq_o      = done_q && !mask_q;
  assign busy_o     = eng_busy;
  assign chip_en_o  = ce_q;
  assign chip_sel_o = csel_q;
  assign buf_sel_o  = bsel_q;
endmodule

// File: rtl/nand_opreg_check.sv
module nand_opreg_check #(
  parameter int OPW = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           irq,
  input logic           done,
  input logic           mask,
  input logic [OPW-1:0] op,
  input logic           wr_op,
  input logic           srst,
  input logic [15:0]    uhi
);
  p_op_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $onehot(op));

  p_done_after_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $fell(busy));

  p_busy_write_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_op) |=> (op == $past(op) || op == '0));

  p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mask |-> !irq);

  p_soft_defaults_r9: assert property (@(posedge clk) disable iff (!rst_n)
    srst |-> (!busy && !done && uhi == 16'hFFFF));
endmodule

bind nand_opreg_block nand_opreg_check #(.OPW(nand_opreg_pkg::OP_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy_o), .irq(irq_o), .done(done_q),
  .mask(mask_q), .op(op_q), .wr_op(wr_op), .srst(srst_active), .uhi(uhi_q)
);

// File: tb/nand_opreg_block_test.sv
module nand_opreg_block_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq_o, busy_o, chip_en_o;
  logic [1:0]  chip_sel_o;
  logic [2:0]  buf_sel_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  nand_opreg_block uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o),
    .busy_o(busy_o), .chip_en_o(chip_en_o), .chip_sel_o(chip_sel_o),
    .buf_sel_o(buf_sel_o)
  );

  always #10 clk = ~clk;

  function automatic logic [15:0] exp_bufsel(logic [15:0] v);
    return v & 16'h0067;
  endfunction
  function automatic logic [15:0] exp_cfg(logic [15:0] v);
    return v & 16'h0690;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a negedge; the write lands on the next posedge
  task automatic wr(logic [2:0] a, logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy_o && n < 400) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [15:0] r;
    int n;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd0, r); check("R1 bufsel", r, 16'h0000);
    rd(3'd1, r); check("R1 cfg", r, 16'h0000);
    rd(3'd2, r); check("R1 op", r, 16'h0000);
    rd(3'd3, r); check("R1 spare", r, 16'h0000);
    rd(3'd4, r); check("R1 wprot", r, 16'h0000);
    rd(3'd5, r); check("R1 ulo", r, 16'h0000);
    rd(3'd6, r); check("R1 uhi", r, 16'hFFFF);
    rd(3'd7, r); check("R1 lat", r, 16'h0004);
    check("R1 pins", {13'd0, irq_o, busy_o, chip_en_o}, 16'h0000);

    // R2 / R3 random field writes
    for (int i = 0; i < 20; i++) begin
      logic [15:0] v;
      v = 16'($urandom());
      wr(3'd0, v);
      rd(3'd0, r); check("R2 bufsel readback", r, exp_bufsel(v));
      check("R2 pins", {11'd0, chip_sel_o, buf_sel_o}, {11'd0, v[6:5], v[2:0]});
      v[6] = 1'b0;
      wr(3'd1, v);
      rd(3'd1, r); check("R3 cfg readback", r, exp_cfg(v));
      check("R3 chip enable", {15'd0, chip_en_o}, {15'd0, v[7]});
    end
    wr(3'd1, 16'h0000);

    // R10 storage registers
    wr(3'd3, 16'hA5C3); rd(3'd3, r); check("R10 spare", r, 16'hA5C3);
    wr(3'd4, 16'hFFFD); rd(3'd4, r); check("R10 wprot", r, 16'h0005);
    wr(3'd5, 16'h1357); rd(3'd5, r); check("R10 ulo", r, 16'h1357);
    wr(3'd6, 16'h8642); rd(3'd6, r); check("R10 uhi", r, 16'h8642);
    wr(3'd7, 16'h1203); rd(3'd7, r); check("R10 lat width", r, 16'h0003);

    // R4 random launches with random latency
    for (int i = 0; i < 12; i++) begin
      int lat, k;
      lat = 1 + int'($urandom_range(0, 9));
      k = int'($urandom_range(0, 5));
      wr(3'd7, 16'(lat));
      wr(3'd2, 16'h0001 << k);
      rd(3'd2, r); check("R4 op bit while busy", r, 16'h0001 << k);
      count_busy(n);
      check("R4 busy length", 16'(n), 16'(lat));
      rd(3'd2, r); check("R4 done after finish", r, 16'h8000);
      check("R8 irq set", {15'd0, irq_o}, 16'h0001);
      wr(3'd2, 16'h0000);
      rd(3'd2, r); check("R7 done cleared", r, 16'h0000);
    end

    // R10 latency zero acts as one
    wr(3'd7, 16'h0000);
    wr(3'd2, 16'h0008);
    count_busy(n);
    check("R10 lat zero", 16'(n), 16'd1);

    // R7 write with bit 15 set keeps done
    wr(3'd2, 16'h8000);
    rd(3'd2, r); check("R7 done kept", r, 16'h8000);
    // R8 mask gates irq
    wr(3'd1, 16'h0010);
    check("R8 irq masked", {15'd0, irq_o}, 16'h0000);
    wr(3'd1, 16'h0000);
    check("R8 irq unmasked", {15'd0, irq_o}, 16'h0001);
    wr(3'd2, 16'h0000);
    check("R8 irq cleared", {15'd0, irq_o}, 16'h0000);

    // R5 no launch on zero or several bits
    wr(3'd2, 16'h0003);
    check("R5 multi bit", {15'd0, busy_o}, 16'h0000);
    rd(3'd2, r); check("R5 multi readback", r, 16'h0000);
    wr(3'd2, 16'h0040);
    check("R5 zero op bits", {15'd0, busy_o}, 16'h0000);

    // R6 write during busy ignored, including collision with completion
    wr(3'd7, 16'd3);
    wr(3'd2, 16'h0004);
    wr(3'd2, 16'h0010);
    rd(3'd2, r); check("R6 busy write ignored", r, 16'h0004);
    @(negedge clk);
    wr(3'd2, 16'h0000);
    rd(3'd2, r); check("R6 collision done wins", r, 16'h8000);
    check("R6 collision irq", {15'd0, irq_o}, 16'h0001);
    wr(3'd2, 16'h0000);

    // R9 soft reset
    wr(3'd6, 16'h0F0F);
    wr(3'd1, 16'h0080);
    wr(3'd7, 16'd20);
    wr(3'd2, 16'h0020);
    wr(3'd1, 16'h0040);
    rd(3'd1, r); check("R9 reset bit reads 1", r, 16'h0040);
    check("R9 op aborted", {15'd0, busy_o}, 16'h0000);
    rd(3'd6, r); check("R9 uhi default", r, 16'hFFFF);
    wr(3'd5, 16'h1234);
    repeat (6) @(negedge clk);
    rd(3'd1, r); check("R9 reset bit cleared", r, 16'h0000);
    rd(3'd5, r); check("R9 write ignored", r, 16'h0000);
    rd(3'd7, r); check("R9 lat default", r, 16'h0004);
    rd(3'd2, r); check("R9 op default", r, 16'h0000);

    finish_run();
  end
endmodule